// File: doc/BRIEF.md
# Floating-Point Status Register Unit

This block keeps the status register that sits beside a floating-point datapath. After each arithmetic operation that reports IEEE exception flags, it records those flags as the current exceptions and checks them against a per-flag trap-enable mask. If any enabled flag is raised, it marks the register with the IEEE trap type and issues a one-cycle trap request. Otherwise the flags are added to the sticky accrued field.

Compare results update one of four two-bit condition-code pairs. An unordered compare either sets the accrued invalid bit or, when the invalid trap is enabled or the compare is signaling, sets the current invalid bit and requests a trap. The two-bit rounding field is presented decoded. A write port loads the whole register. The arithmetic itself and trap vectoring belong elsewhere.

Top module: `fsr_unit`

## Requirements
- R1: After reset the register reads zero, `trapPulse` is low and `roundMode` is 0 (nearest-even).
- R2: An operation strobe with no write and no compare replaces the current-exception field [4:0] with `excFlags`. The flag order is bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero and bit 0 inexact.
- R3: If `excFlags` AND the trap-enable field [27:23] (same flag order) is zero, the flags are ORed into the accrued field [9:5]. The trap-type field [16:14] is unchanged and no trap is requested.
- R4: If `excFlags` AND the trap-enable field is nonzero, the trap-type field becomes 3'b001, the accrued field is unchanged, and `trapPulse` is high for exactly the one cycle after the operation.
- R5: A compare writes the selected pair as 00 for equal, 01 for less, 10 for greater and 11 for unordered (`cmpResult` codes 0, 1, 2 and 3). Pair 0 sits at [11:10] and pairs 1, 2 and 3 at [33:32], [35:34] and [37:36]. The other pairs are untouched.
- R6: An unordered compare with invalid-trap enable (bit 27) clear and `cmpSignal` low sets accrued invalid (bit 9), leaves the current field unchanged and requests no trap.
- R7: An unordered compare with bit 27 set or `cmpSignal` high sets current invalid (bit 4) and sets trap type 3'b001. It leaves the accrued field unchanged and requests a trap.
- R8: An ordered compare (equal, less or greater) changes no exception or trap-type bit and requests no trap, even when signaling.
- R9: `roundMode` decodes bits [31:30]: 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R10: A write loads all 64 bits from `wrData`. It takes priority over a compare or operation in the same cycle, which then has no effect and requests no trap.
- R11: When a compare and an operation arrive in the same cycle without a write, only the compare takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Load the whole register |
| wrData | input | 64 | Value to load |
| opValid | input | 1 | Arithmetic operation completed with flags |
| excFlags | input | 5 | IEEE exception flags of that operation |
| cmpValid | input | 1 | Compare completed |
| cmpResult | input | 2 | 0 equal, 1 less, 2 greater, 3 unordered |
| cmpSel | input | 2 | Target condition-code pair 0..3 |
| cmpSignal | input | 1 | Compare is of the signaling kind |
| fsrValue | output | 64 | Register contents |
| roundMode | output | 2 | Decoded rounding direction |
| trapPulse | output | 1 | One-cycle trap request |

## Verification
Every result is due exactly one cycle after its stimulus: the register and the trap request are both captured at the edge that samples the inputs. The bench drives each stimulus on a falling edge, lets one rising edge pass, and compares the whole register and the trap line on the next falling edge against a bench-side model. A trap pulse that outlived its cycle would show up in the following vector's check. Operations are swept over every flag pattern against every trap-enable mask, and compares over every result, pair, signaling kind and invalid-enable setting.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int REG_W      = 64;
  localparam int EXC_W      = 5;
  localparam int CEXC_LSB   = 0;
  localparam int ACC_SHIFT  = 5;
  localparam int AEXC_LSB   = CEXC_LSB + ACC_SHIFT;
  localparam int NV_POS     = 4;
  localparam int FCC_BASE   = 10;
  localparam int FCC_FAR    = 22;
  localparam int FCC_W      = 2;
  localparam int FCC_N      = 4;
  localparam int SEL_W      = $clog2(FCC_N);
  localparam int FTT_LSB    = 14;
  localparam int FTT_W      = 3;
  localparam logic [FTT_W-1:0] FTT_IEEE = 3'd1;
  localparam int TEM_SHIFT  = 23;
  localparam int TEM_LSB    = CEXC_LSB + TEM_SHIFT;
  localparam int RND_LSB    = 30;
  localparam int RND_W      = 2;

  typedef enum logic [RND_W-1:0] {
    RND_NEAREST = 2'd0, RND_ZERO = 2'd1, RND_POS_INF = 2'd2, RND_NEG_INF = 2'd3
  } rnd_e;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0, CMP_LT = 2'd1, CMP_GT = 2'd2, CMP_UN = 2'd3
  } cmp_e;

  typedef struct packed {
    logic             load;
    logic             setCexc;
    logic             mergeAcc;
    logic             orCexcNv;
    logic             setAccNv;
    logic             markTrap;
    logic             writeFcc;
    logic [FCC_W-1:0] fccVal;
    logic [SEL_W-1:0] fccSel;
    logic [EXC_W-1:0] excVal;
  } strobe_t;

  function automatic int fccLsb(input int idx);
    return (idx == 0) ? FCC_BASE : FCC_BASE + FCC_FAR + FCC_W * (idx - 1);
  endfunction
endpackage

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             opValid,
  input  logic [EXC_W-1:0] excFlags,
  input  logic             cmpValid,
  input  logic [1:0]       cmpResult,
  input  logic [SEL_W-1:0] cmpSel,
  input  logic             cmpSignal,
  input  logic [EXC_W-1:0] temField,
  output strobe_t          strb,
  output logic             trapPulse
);
  cmp_e cmpKind;
  logic pastValid;

  assign cmpKind = cmp_e'(cmpResult);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      strb.load = 1'b1;
    end else if (cmpValid) begin
      strb.writeFcc = 1'b1;
      strb.fccSel   = cmpSel;
      strb.fccVal   = {(cmpKind == CMP_GT) || (cmpKind == CMP_UN),
                       (cmpKind == CMP_LT) || (cmpKind == CMP_UN)};
      if (cmpKind == CMP_UN) begin
        if (temField[NV_POS] || cmpSignal) begin
          strb.orCexcNv = 1'b1;
          strb.markTrap = 1'b1;
        end else begin
          strb.setAccNv = 1'b1;
        end
      end
    end else if (opValid) begin
      strb.setCexc = 1'b1;
      strb.excVal  = excFlags;
      if ((excFlags & temField) != '0) strb.markTrap = 1'b1;
      else                             strb.mergeAcc = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapPulse <= 1'b0;
      pastValid <= 1'b0;
    end else begin
      trapPulse <= strb.markTrap;
      pastValid <= 1'b1;
    end
  end

  // R4, R7: a trap request always follows an operation or compare
  p_trap_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && trapPulse) |-> ($past(opValid || cmpValid) && !$past(wrEn)));

  // R10: a write never yields a trap request
  p_write_no_trap_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !trapPulse);

  // R8: ordered compares never trap
  p_ordered_no_trap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && cmpValid && cmpResult != 2'd3) |=> !trapPulse);
endmodule

// File: rtl/fsr_datapath.sv
module fsr_datapath
  import fsr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [REG_W-1:0] wrData,
  input  logic             trapPulse,
  output logic [REG_W-1:0] regQ,
  output logic [RND_W-1:0] roundMode
);
  logic [REG_W-1:0] regD;
  logic [FCC_N-1:0][FCC_W-1:0] fccNext;
  logic pastValid;
  rnd_e rndDec;

  for (genvar g = 0; g < FCC_N; g++) begin : g_fcc
    localparam int Lsb = fccLsb(g);
    assign fccNext[g] = (strb.writeFcc && strb.fccSel == SEL_W'(g))
                        ? strb.fccVal : regQ[Lsb +: FCC_W];
  end

  always_comb begin
    regD = regQ;
    if (strb.load) begin
      regD = wrData;
    end else begin
      if (strb.setCexc)  regD[CEXC_LSB +: EXC_W] = strb.excVal;
      if (strb.orCexcNv) regD[CEXC_LSB + NV_POS] = 1'b1;
      if (strb.mergeAcc) regD[AEXC_LSB +: EXC_W] = regQ[AEXC_LSB +: EXC_W] | strb.excVal;
      if (strb.setAccNv) regD[AEXC_LSB + NV_POS] = 1'b1;
      if (strb.markTrap) regD[FTT_LSB +: FTT_W]  = FTT_IEEE;
      for (int k = 0; k < FCC_N; k++) regD[fccLsb(k) +: FCC_W] = fccNext[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regQ      <= '0;
      pastValid <= 1'b0;
    end else begin
      regQ      <= regD;
      pastValid <= 1'b1;
    end
  end

  always_comb begin
    case (regQ[RND_LSB +: RND_W])
      2'd0:    rndDec = RND_NEAREST;
      2'd1:    rndDec = RND_ZERO;
      2'd2:    rndDec = RND_POS_INF;
      default: rndDec = RND_NEG_INF;
    endcase
  end
  assign roundMode = rndDec;

  // R10: a write lands whole
  p_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(strb.load)) |-> regQ == $past(wrData));

  // R3: accrued field keeps every merged flag
  p_merge_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(strb.mergeAcc)) |->
      ((regQ[AEXC_LSB +: EXC_W] & $past(strb.excVal)) == $past(strb.excVal)));

  // R4, R7: trap request comes with the IEEE trap type in the register
  p_trap_type_r7: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> regQ[FTT_LSB +: FTT_W] == FTT_IEEE);

  // R8: ordered compares leave exception fields alone
  p_ordered_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(strb.writeFcc) && !$past(trapPulse) && !trapPulse
     && !$past(strb.setAccNv))
      |-> regQ[AEXC_LSB + EXC_W - 1 : CEXC_LSB] == $past(regQ[AEXC_LSB + EXC_W - 1 : CEXC_LSB]));
endmodule

// File: rtl/fsr_unit.sv
module fsr_unit
  import fsr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             opValid,
  input  logic [EXC_W-1:0] excFlags,
  input  logic             cmpValid,
  input  logic [1:0]       cmpResult,
  input  logic [SEL_W-1:0] cmpSel,
  input  logic             cmpSignal,
  output logic [REG_W-1:0] fsrValue,
  output logic [RND_W-1:0] roundMode,
  output logic             trapPulse
);
  strobe_t strb;

  fsr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .opValid(opValid), .excFlags(excFlags),
    .cmpValid(cmpValid), .cmpResult(cmpResult), .cmpSel(cmpSel), .cmpSignal(cmpSignal),
    .temField(fsrValue[TEM_LSB +: EXC_W]), .strb(strb), .trapPulse(trapPulse)
  );

  fsr_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .trapPulse(trapPulse),
    .regQ(fsrValue), .roundMode(roundMode)
  );
endmodule

// File: tb/fsr_unit_tb_top.sv
`timescale 1ns/1ps
module fsr_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, opValid = 0, cmpValid = 0, cmpSignal = 0;
  logic [63:0] wrData = '0;
  logic [4:0] excFlags = '0;
  logic [1:0] cmpResult = '0, cmpSel = '0;
  logic [63:0] fsrValue;
  logic [1:0] roundMode;
  logic trapPulse;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [63:0] expReg = '0;

  always #10 clk = ~clk;

  fsr_unit dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .opValid(opValid),
    .excFlags(excFlags), .cmpValid(cmpValid), .cmpResult(cmpResult), .cmpSel(cmpSel),
    .cmpSignal(cmpSignal), .fsrValue(fsrValue), .roundMode(roundMode), .trapPulse(trapPulse)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [64:0] model(input logic [63:0] r, input logic wr,
      input logic [63:0] wd, input logic op, input logic [4:0] fl, input logic cmp,
      input logic [1:0] res, input logic [1:0] sel, input logic sig);
    logic [63:0] n;
    logic t;
    int p;
    n = r; t = 0;
    if (wr) n = wd;
    else if (cmp) begin
      p = (sel == 0) ? 10 : 30 + 2 * sel;
      n[p]   = (res == 1) || (res == 3);
      n[p+1] = (res == 2) || (res == 3);
      if (res == 3) begin
        if (r[27] || sig) begin n[4] = 1; n[16:14] = 3'b001; t = 1; end
        else n[9] = 1;
      end
    end else if (op) begin
      n[4:0] = fl;
      if ((fl & r[27:23]) != 0) begin n[16:14] = 3'b001; t = 1; end
      else n[9:5] = r[9:5] | fl;
    end
    return {t, n};
  endfunction

  task automatic apply(input string tag, input logic wr, input logic [63:0] wd,
      input logic op, input logic [4:0] fl, input logic cmp, input logic [1:0] res,
      input logic [1:0] sel, input logic sig);
    logic [64:0] m;
    m = model(expReg, wr, wd, op, fl, cmp, res, sel, sig);
    wrEn = wr; wrData = wd; opValid = op; excFlags = fl;
    cmpValid = cmp; cmpResult = res; cmpSel = sel; cmpSignal = sig;
    @(posedge clk); @(negedge clk);
    wrEn = 0; opValid = 0; cmpValid = 0; cmpSignal = 0;
    expReg = m[63:0];
    chk({tag, " reg"}, fsrValue, expReg);
    chk({tag, " trap"}, 64'(trapPulse), 64'(m[64]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [63:0] wd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reg", fsrValue, 64'h0);
    chk("R1 trap", 64'(trapPulse), 64'h0);
    chk("R1 round", 64'(roundMode), 64'h0);

    // Operation sweep: every trap mask against every flag pattern
    for (int tem = 0; tem < 32; tem++) begin
      for (int fl = 0; fl < 32; fl++) begin
        wd = 64'h0;
        wd[27:23] = 5'(tem);
        wd[9:5]   = 5'(tem) ^ 5'h15;
        wd[4:0]   = 5'(fl) ^ 5'h0A;
        wd[37:32] = 6'(tem + fl);
        apply("R10 load", 1, wd, 0, 0, 0, 0, 0, 0);
        if ((5'(fl) & 5'(tem)) != 0) apply("R4 op trap", 0, 0, 1, 5'(fl), 0, 0, 0, 0);
        else                          apply("R3 op merge", 0, 0, 1, 5'(fl), 0, 0, 0, 0);
        chk("R2 cexc", 64'(fsrValue[4:0]), 64'(fl));
      end
    end
    // R4: the pulse lasts one cycle
    apply("R4 idle after", 0, 0, 0, 0, 0, 0, 0, 0);

    // Compare sweep
    for (int nvEn = 0; nvEn < 2; nvEn++)
      for (int sig = 0; sig < 2; sig++)
        for (int sel = 0; sel < 4; sel++)
          for (int res = 0; res < 4; res++) begin
            wd = 64'hA5A5_5A5A_0300_0000 ^ 64'(sel * 7 + res);
            wd[27] = 1'(nvEn);
            wd[9] = 0;
            wd[4] = 0;
            wd[16:14] = 0;
            apply("R10 load", 1, wd, 0, 0, 0, 0, 0, 0);
            if (res == 3 && (nvEn == 1 || sig == 1))
              apply("R7 unord trap", 0, 0, 0, 0, 1, 2'(res), 2'(sel), 1'(sig));
            else if (res == 3)
              apply("R6 unord acc", 0, 0, 0, 0, 1, 2'(res), 2'(sel), 1'(sig));
            else
              apply("R8 ordered", 0, 0, 0, 0, 1, 2'(res), 2'(sel), 1'(sig));
            chk("R5 fcc", 64'(fsrValue[(sel == 0) ? 10 : 30 + 2 * sel +: 2]), 64'(res));
          end

    // Rounding decode
    for (int m = 0; m < 4; m++) begin
      wd = 64'h0;
      wd[31:30] = 2'(m);
      apply("R10 load", 1, wd, 0, 0, 0, 0, 0, 0);
      chk("R9 round", 64'(roundMode), 64'(m));
    end

    // Write priority over a trapping operation and a trapping compare
    apply("R10 load", 1, 64'h0F80_0000, 0, 0, 0, 0, 0, 0);
    apply("R10 wins op", 1, 64'h1234_0000_0000_0000, 1, 5'h1F, 0, 0, 0, 0);
    apply("R10 load", 1, 64'h0F80_0000, 0, 0, 0, 0, 0, 0);
    apply("R10 wins cmp", 1, 64'h0000_00FF_0000_0000, 0, 0, 1, 3, 2, 1);

    // Compare beats a simultaneous operation
    apply("R10 load", 1, 64'h0F80_0000, 0, 0, 0, 0, 0, 0);
    apply("R11 cmp over op", 0, 0, 1, 5'h1F, 1, 1, 1, 0);
    apply("R11 cmp over op unord", 0, 0, 1, 5'h03, 1, 3, 3, 0);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule